// File: doc/BRIEF.md
# DTMF tone-pair frequency classifier

This block identifies which of the sixteen telephone keypad tone pairs is present on two squared tone lines. One line carries the output of the low-group band comparator and the other carries the high-group comparator. Both are full-swing logic signals running at the tone frequency. The block has no arithmetic signal processing. It counts reference clock cycles between rising edges, so each group gets a stream of period measurements. Each measurement is sorted into one of four frequency bins for that group.

A group counts as valid only after four consecutive measured periods have landed in the same bin. This is the averaging step. Small steady deviations still pass, but signals with an unstable period, such as speech, never settle. When both groups are valid at the same time, the block raises an early-steering flag and drives the 4-bit key code. A downstream steering block uses the flag to validate duration and latch the code.

The flag falls at once in three cases:
- a period outside the held bin arrives;
- a group's tone stops;
- a group's tone changes.

The reference clock is 3.579545 MHz by default. It is a parameter, so every bin limit and timeout scales with it.

Top module: `dtmf_pair_classifier`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `est` is 0 and `code` is 0.
- R2: Each tone input is synchronised, and a group's period is the number of clock cycles between two rising edges. A group becomes valid only when NPER (default 4) consecutive periods all fall in the same bin. The first rising edge after reset or after a timeout only starts a measurement. With tones starting from silence, `est` stays 0 until the low group has produced NPER+1 rising edges.
- R3: The bins are 697, 770, 852 and 941 Hz for the low group, and 1209, 1336, 1477 and 1633 Hz for the high group. A period is accepted into a bin when it lies between CLK_HZ/(f·1.025) rounded up and CLK_HZ/(f·0.975) rounded down. A tone 2 % off nominal is therefore accepted, and a tone 4 % off nominal is rejected.
- R4: `est` is 1 only while both groups are valid together. A single valid group, low or high, leaves `est` at 0.
- R5: A measured period that falls outside the group's current bin drops `est` at that edge. This covers a move to another bin and a period in no bin. Periods that alternate between two bins never make the group valid.
- R6: When a group sees no rising edge for 5/4 of the upper period limit of its lowest tone, that group's validity is cleared and `est` falls.
- R7: While `est` is 1, `code` gives the key. Rows are the low tones in ascending order and columns are the high tones in ascending order. Keys 1–9 give codes 1–9. Key 0 (row 4, column 2) gives 10, key * (row 4, column 1) gives 11 and key # (row 4, column 3) gives 12. Column 4, rows 1–4, gives 13, 14, 15 and 0. While `est` is 0, `code` is 0.
- R8: `code` stays stable for as long as `est` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (CLK_HZ) |
| rst | input | 1 | Synchronous reset, active high |
| tone_lo | input | 1 | Squared low-group tone |
| tone_hi | input | 1 | Squared high-group tone |
| est | output | 1 | Early steering: both groups valid |
| code | output | 4 | Key code of the detected pair, 0 when `est` is low |

## Verification
The hardest state to reach is a drop of `est` caused by one out-of-bin period while edges keep arriving. In this state the timeout never fires, so the drop can only come from the bin comparison. The bench reaches it in two ways. First, it changes the low tone's period in mid-stream without any gap, checks that `est` is low within one new period, and then checks that the new key is acquired. Second, it feeds a low tone whose period alternates between two adjacent bins, which must never become valid. The acceptance edges are approached with tones placed 2 % and 4 % away from nominal on each group, with the clock parameter reduced so that each period is a few hundred cycles.

// File: rtl/dtmf_pair_classifier.sv
module dtmf_pair_classifier #(
  parameter int CLK_HZ  = 3579545,
  parameter int TOL_PML = 25,
  parameter int NPER    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tone_lo,
  input  logic       tone_hi,
  output logic       est,
  output logic [3:0] code
);

  function automatic longint tone_hz(int g, int i);
    if (g == 0)
      case (i)
        0: return 697;
        1: return 770;
        2: return 852;
        default: return 941;
      endcase
    else
      case (i)
        0: return 1209;
        1: return 1336;
        2: return 1477;
        default: return 1633;
      endcase
  endfunction

  function automatic longint lo_lim(int g, int i);
    longint d;
    d = tone_hz(g, i) * (1000 + TOL_PML);
    return (longint'(CLK_HZ) * 1000 + d - 1) / d;
  endfunction

  function automatic longint hi_lim(int g, int i);
    return (longint'(CLK_HZ) * 1000) / (tone_hz(g, i) * (1000 - TOL_PML));
  endfunction

  function automatic longint to_lim(int g);
    return hi_lim(g, 0) * 5 / 4;
  endfunction

  function automatic logic [3:0] key_code(logic [1:0] r, logic [1:0] c);
    if (c == 2'd3) return 4'd13 + {2'b00, r};
    if (r == 2'd3)
      case (c)
        2'd0: return 4'd11;
        2'd1: return 4'd10;
        default: return 4'd12;
      endcase
    return ({2'b00, r} << 1) + {2'b00, r} + {2'b00, c} + 4'd1;
  endfunction

  localparam int TO_LO = int'(to_lim(0));
  localparam int TO_HI = int'(to_lim(1));
  localparam int CW    = $clog2(TO_LO + 2);
  localparam int RW    = $clog2(NPER + 1);
  localparam logic [RW-1:0] FULL = RW'(NPER);

  logic [1:0]       tone;
  logic [2:0]       sy    [2];
  logic [CW-1:0]    cnt   [2];
  logic [RW-1:0]    run   [2];
  logic [1:0]       bin   [2];
  logic [1:0]       nbin  [2];
  logic [1:0][3:0]  inb;
  logic [1:0]       rise, tmo, hit, armed, ok;

  assign tone = {tone_hi, tone_lo};

  for (genvar g = 0; g < 2; g++) begin : gen_grp
    localparam logic [CW-1:0] TOG = CW'(to_lim(g));

    for (genvar i = 0; i < 4; i++) begin : gen_bin
      localparam logic [CW-1:0] LB = CW'(lo_lim(g, i));
      localparam logic [CW-1:0] HB = CW'(hi_lim(g, i));
      assign inb[g][i] = (cnt[g] >= LB) && (cnt[g] <= HB);
    end

    assign rise[g] = sy[g][1] & ~sy[g][2];
    assign tmo[g]  = cnt[g] == TOG;
    assign hit[g]  = |inb[g];
    assign nbin[g] = {inb[g][3] | inb[g][2], inb[g][3] | inb[g][1]};
    assign ok[g]   = run[g] == FULL;

    always_ff @(posedge clk) begin
      if (rst) begin
        sy[g]    <= '0;
        cnt[g]   <= '0;
        run[g]   <= '0;
        bin[g]   <= '0;
        armed[g] <= 1'b0;
      end else begin
        sy[g] <= {sy[g][1:0], tone[g]};
        if (rise[g]) begin
          cnt[g]   <= CW'(1);
          armed[g] <= 1'b1;
          if (!armed[g] || !hit[g]) begin
            run[g] <= '0;
          end else if (run[g] != '0 && nbin[g] == bin[g]) begin
            if (run[g] != FULL) run[g] <= run[g] + RW'(1);
          end else begin
            run[g] <= RW'(1);
            bin[g] <= nbin[g];
          end
        end else if (tmo[g]) begin
          armed[g] <= 1'b0;
          run[g]   <= '0;
        end else begin
          cnt[g] <= cnt[g] + CW'(1);
        end
      end
    end
  end

  assign est  = ok[0] & ok[1];
  assign code = est ? key_code(bin[0], bin[1]) : 4'd0;

endmodule

// File: rtl/dtmf_pair_classifier_chk.sv
module dtmf_pair_classifier_chk #(
  parameter int CW    = 8,
  parameter int RW    = 3,
  parameter int NPER  = 4,
  parameter int TO_LO = 100,
  parameter int TO_HI = 100
) (
  input logic          clk,
  input logic          rst,
  input logic          est,
  input logic [3:0]    code,
  input logic          lo_rise,
  input logic          hi_rise,
  input logic          lo_tmo,
  input logic          hi_tmo,
  input logic          lo_ok,
  input logic          hi_ok,
  input logic [CW-1:0] cnt_lo,
  input logic [CW-1:0] cnt_hi,
  input logic [RW-1:0] run_lo,
  input logic [RW-1:0] run_hi
);

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!est && code == 4'd0));

  p_est_after_edge_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(est) |-> $past(lo_rise || hi_rise));

  p_run_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (int'(run_lo) <= NPER) && (int'(run_hi) <= NPER));

  p_lo_gain_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(lo_ok) |-> $past(lo_rise));

  p_lo_drop_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(lo_ok) |-> $past(lo_rise || lo_tmo));

  p_hi_drop_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(hi_ok) |-> $past(hi_rise || hi_tmo));

  p_cnt_sat_r6: assert property (@(posedge clk) disable iff (rst)
    (int'(cnt_lo) <= TO_LO) && (int'(cnt_hi) <= TO_HI));

  p_code_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (est && $past(est)) |-> $stable(code));

endmodule

bind dtmf_pair_classifier dtmf_pair_classifier_chk #(
  .CW(CW), .RW(RW), .NPER(NPER), .TO_LO(TO_LO), .TO_HI(TO_HI)
) u_chk (
  .clk(clk), .rst(rst), .est(est), .code(code),
  .lo_rise(rise[0]), .hi_rise(rise[1]),
  .lo_tmo(tmo[0]), .hi_tmo(tmo[1]),
  .lo_ok(ok[0]), .hi_ok(ok[1]),
  .cnt_lo(cnt[0]), .cnt_hi(cnt[1]),
  .run_lo(run[0]), .run_hi(run[1])
);

// File: tb/dtmf_pair_classifier_test.sv
module dtmf_pair_classifier_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 200000;
  localparam int WAIT_ON    = 2600;
  localparam int WAIT_OFF   = 800;

  localparam int LF [4] = '{697, 770, 852, 941};
  localparam int HF [4] = '{1209, 1336, 1477, 1633};

  // {row, column, expected code}
  localparam logic [7:0] VEC [16] = '{
    {2'd0, 2'd0, 4'd1},  {2'd0, 2'd1, 4'd2},  {2'd0, 2'd2, 4'd3},  {2'd0, 2'd3, 4'd13},
    {2'd1, 2'd0, 4'd4},  {2'd1, 2'd1, 4'd5},  {2'd1, 2'd2, 4'd6},  {2'd1, 2'd3, 4'd14},
    {2'd2, 2'd0, 4'd7},  {2'd2, 2'd1, 4'd8},  {2'd2, 2'd2, 4'd9},  {2'd2, 2'd3, 4'd15},
    {2'd3, 2'd0, 4'd11}, {2'd3, 2'd1, 4'd10}, {2'd3, 2'd2, 4'd12}, {2'd3, 2'd3, 4'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tone_lo = 1'b0;
  logic tone_hi = 1'b0;
  logic est;
  logic [3:0] code;

  int lp = 0, la = 0, hp = 0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  dtmf_pair_classifier #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst(rst), .tone_lo(tone_lo), .tone_hi(tone_hi),
    .est(est), .code(code)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int per(int f, int dev);
    longint d;
    d = longint'(f) * (1000 + dev);
    return int'((longint'(CLK_HZ) * 1000 + d / 2) / d);
  endfunction

  initial begin
    bit alt;
    alt = 1'b0;
    forever begin
      int cur;
      if (lp == 0) begin
        tone_lo = 1'b0;
        @(negedge clk);
      end else begin
        cur = (la != 0 && alt) ? la : lp;
        alt = !alt;
        tone_lo = 1'b1;
        repeat (cur / 2) @(negedge clk);
        tone_lo = 1'b0;
        repeat (cur - cur / 2) @(negedge clk);
      end
    end
  end

  initial begin
    forever begin
      int cur;
      if (hp == 0) begin
        tone_hi = 1'b0;
        @(negedge clk);
      end else begin
        cur = hp;
        tone_hi = 1'b1;
        repeat (cur / 2) @(negedge clk);
        tone_hi = 1'b0;
        repeat (cur - cur / 2) @(negedge clk);
      end
    end
  end

  task automatic chk(input string req, input logic e_exp, input logic [3:0] c_exp);
    checks++;
    if (est !== e_exp || code !== c_exp) begin
      fails++;
      $display("FAIL %s: est/code got %0b/%0d expected %0b/%0d", req, est, code, e_exp, c_exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    cyc(3);
    chk("R1 during reset", 1'b0, 4'd0);
    rst = 1'b0;
    cyc(1);
    chk("R1 after release", 1'b0, 4'd0);

    for (int k = 0; k < 16; k++) begin
      lp = per(LF[VEC[k][7:6]], 0);
      hp = per(HF[VEC[k][5:4]], 0);
      cyc(WAIT_ON);
      chk("R7 key table", 1'b1, VEC[k][3:0]);
      lp = 0;
      hp = 0;
      cyc(WAIT_OFF);
      chk("R6 silence clears", 1'b0, 4'd0);
    end

    // R2: acquisition needs NPER+1 low-group edges
    lp = per(697, 0);
    hp = per(1209, 0);
    cyc(1000);
    chk("R2 not before four periods", 1'b0, 4'd0);
    cyc(300);
    chk("R2 valid after four periods", 1'b1, 4'd1);

    // R5: low tone switches 697 -> 770 without a gap
    lp = per(770, 0);
    cyc(600);
    chk("R5 drop on bin change", 1'b0, 4'd0);
    cyc(1000);
    chk("R5 reacquire new key", 1'b1, 4'd4);

    // R6: only the low tone stops
    lp = 0;
    cyc(WAIT_OFF);
    chk("R6 low timeout", 1'b0, 4'd0);
    hp = 0;
    cyc(WAIT_OFF);

    // R4: one group alone
    lp = per(852, 0);
    cyc(WAIT_ON);
    chk("R4 low only", 1'b0, 4'd0);
    lp = 0;
    hp = per(1477, 0);
    cyc(WAIT_ON);
    chk("R4 high only", 1'b0, 4'd0);

    // R8: code held steady while est stays high
    lp = per(852, 0);
    cyc(WAIT_ON);
    for (int s = 0; s < 5; s++) begin
      chk("R8 stable code", 1'b1, 4'd9);
      cyc(300);
    end
    lp = 0;
    hp = 0;
    cyc(WAIT_OFF);

    // R3: tolerance edges on the 941/1336 pair (key 0, code 10)
    lp = per(941, 20);
    hp = per(1336, 20);
    cyc(WAIT_ON);
    chk("R3 +2% accepted", 1'b1, 4'd10);
    lp = per(941, -20);
    hp = per(1336, -20);
    cyc(WAIT_ON);
    chk("R3 -2% accepted", 1'b1, 4'd10);
    lp = per(941, 40);
    hp = per(1336, 0);
    cyc(WAIT_ON);
    chk("R3 low +4% rejected", 1'b0, 4'd0);
    lp = per(941, 0);
    hp = per(1336, -40);
    cyc(WAIT_ON);
    chk("R3 high -4% rejected", 1'b0, 4'd0);
    lp = 0;
    hp = 0;
    cyc(WAIT_OFF);

    // R5: unstable period alternating between two bins
    lp = per(697, 0);
    la = per(770, 0);
    hp = per(1209, 0);
    cyc(WAIT_ON);
    chk("R5 alternating periods rejected", 1'b0, 4'd0);
    la = 0;
    cyc(WAIT_ON);
    chk("R5 steady again", 1'b1, 4'd1);

    // R1: reset during an active pair
    rst = 1'b1;
    cyc(2);
    chk("R1 reset mid-tone", 1'b0, 4'd0);
    rst = 1'b0;
    cyc(1);
    chk("R1 right after release", 1'b0, 4'd0);

    finish_up();
  end
endmodule